// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Threshold Unit

This block sits beside a FIFO core and owns the two threshold registers that decide when the FIFO is "almost empty" and "almost full". The core hands it the current word count, and the block returns two active-low flags. The almost-empty flag is registered on the read clock and the almost-full flag on the write clock. Software or a neighbouring controller can set the thresholds at run time, through a parallel word port or a one-bit serial port on the write clock. The values can be read back as whole words on the read clock.

A master reset loads a pair of default thresholds and fixes the programming method. The level of the shared load-select input during that reset decides between a low default with parallel loading and a higher default with serial loading. A partial reset rewinds the load and readback sequences to the start. It keeps the stored thresholds and the chosen method.

Top module: `almost_level_unit`

## Requirements
- R1: While master reset (`mrstN` low) is sampled by `wrClk` with `ofsLoad` low, both thresholds become DEF_LO (127) and the parallel method is chosen.
- R2: While master reset is sampled by `wrClk` with `ofsLoad` high, both thresholds become DEF_HI (1023) and the serial method is chosen.
- R3: With the parallel method, a `wrClk` edge with `wrEn` and `ofsLoad` high stores `dataIn` into the selected threshold. The empty-side threshold is selected first, then the full-side one, and the selection wraps back after that.
- R4: With the serial method, a `wrClk` edge with `serEn` and `ofsLoad` high writes `serIn` into one bit of the selected threshold. The bits go least significant first, OFS_W bits for the empty-side threshold and then OFS_W bits for the full-side one, after which the sequence wraps.
- R5: Load strobes of the method that was not chosen leave both thresholds unchanged.
- R6: A `rdClk` edge with `rdEn` and `ofsLoad` high drives the next threshold onto `dataOut`, zero-extended. The empty-side threshold comes first, then the full-side one, wrapping. The value is visible after that edge. Without that strobe `dataOut` holds its value.
- R7: A partial reset (`prstN` low) returns the load and readback sequences to the empty-side threshold at bit 0. It keeps both thresholds and the programming method.
- R8: `paeN` is low exactly when `fillCount` is at most the empty-side threshold. It is registered on `rdClk`, so it reflects the count sampled at the previous `rdClk` edge.
- R9: `pafN` is low exactly when DEPTH minus `fillCount` is at most the full-side threshold. It is registered on `wrClk`.
- R10: `wrEn` or `serEn` without `ofsLoad` changes no threshold, and `rdEn` without `ofsLoad` leaves `dataOut` unchanged.
- R11: A parallel value with any bit set above the low OFS_W bits stores the all-ones threshold (DEPTH-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mrstN | input | 1 | Master reset, active low, synchronous to each clock |
| prstN | input | 1 | Partial reset, active low |
| ofsLoad | input | 1 | Load select; picks the defaults during master reset |
| wrEn | input | 1 | Parallel threshold write enable |
| serEn | input | 1 | Serial threshold shift enable |
| serIn | input | 1 | Serial threshold data bit |
| dataIn | input | DATA_W | Parallel threshold value |
| rdEn | input | 1 | Threshold readback enable |
| fillCount | input | CNT_W | Stored word count from the FIFO core |
| dataOut | output | DATA_W | Threshold readback word |
| paeN | output | 1 | Almost-empty flag, active low (rdClk) |
| pafN | output | 1 | Almost-full flag, active low (wrClk) |

## Verification
Each threshold write or serial bit takes effect at the `wrClk` edge that samples the strobe. A readback word appears on `dataOut` right after the `rdClk` edge that samples `rdEn` with `ofsLoad`. Each flag follows `fillCount` one edge of its own clock later. The bench drives every input on the falling edge of the clock that samples it and reads `dataOut` on the next falling edge. After changing `fillCount` it waits two full periods of both clocks before it compares the flags. This keeps every comparison clear of the sampling edge and of the registered delay.

// File: rtl/alf_pkg.sv
package alf_pkg;
  typedef struct packed {
    logic defLoad;
    logic defHigh;
    logic parLoad;
    logic serLoad;
    logic serBit;
    logic wrSel;
    logic rdLoad;
    logic rdSel;
  } alf_strobe_t;
endpackage

// File: rtl/alf_ctrl.sv
module alf_ctrl
  import alf_pkg::*;
#(
  parameter int OFS_W = 13,
  localparam int BIT_W = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             ofsLoad,
  input  logic             wrEn,
  input  logic             serEn,
  input  logic             serIn,
  input  logic             rdEn,
  output alf_strobe_t      str,
  output logic [BIT_W-1:0] bitPos
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(OFS_W - 1);

  logic serialMode;
  logic wrIdx;
  logic rdIdx;
  logic active;
  logic activeRd;

  assign active   = mrstN && prstN && ofsLoad;
  assign activeRd = mrstN && prstN && ofsLoad;

  always_comb begin
    str.defLoad = !mrstN;
    str.defHigh = ofsLoad;
    str.parLoad = active && wrEn && !serialMode;
    str.serLoad = active && serEn && serialMode;
    str.serBit  = serIn;
    str.wrSel   = wrIdx;
    str.rdLoad  = activeRd && rdEn;
    str.rdSel   = rdIdx;
  end

  // write-side sequencing: method latch, target index, serial bit position
  always_ff @(posedge wrClk) begin
    if (!mrstN) begin
      serialMode <= ofsLoad;
      wrIdx      <= 1'b0;
      bitPos     <= '0;
    end else if (!prstN) begin
      wrIdx  <= 1'b0;
      bitPos <= '0;
    end else if (str.parLoad) begin
      wrIdx <= ~wrIdx;
    end else if (str.serLoad) begin
      if (bitPos == LAST_BIT) begin
        bitPos <= '0;
        wrIdx  <= ~wrIdx;
      end else begin
        bitPos <= bitPos + 1'b1;
      end
    end
  end

  // read-side sequencing
  always_ff @(posedge rdClk) begin
    if (!mrstN || !prstN) rdIdx <= 1'b0;
    else if (str.rdLoad)  rdIdx <= ~rdIdx;
  end

  assert_bitpos_range_R4: assert property (@(posedge wrClk) disable iff (!mrstN)
    bitPos <= LAST_BIT);

  assert_par_advance_R3: assert property (@(posedge wrClk) disable iff (!mrstN)
    ($past(str.parLoad) && $past(prstN)) |-> (wrIdx != $past(wrIdx)));

  assert_prst_rewind_R7: assert property (@(posedge wrClk) disable iff (!mrstN)
    !$past(prstN) |-> (!wrIdx && bitPos == '0));

  assert_method_kept_R7: assert property (@(posedge wrClk) disable iff (!mrstN)
    $past(mrstN) |-> $stable(serialMode));
endmodule

// File: rtl/alf_datapath.sv
module alf_datapath
  import alf_pkg::*;
#(
  parameter int DEPTH  = 8192,
  parameter int DATA_W = 18,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BIT_W = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  alf_strobe_t       str,
  input  logic [BIT_W-1:0]  bitPos,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  fillCount,
  output logic [DATA_W-1:0] dataOut,
  output logic              paeN,
  output logic              pafN
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [OFS_W-1:0] ofsReg [2];
  logic [OFS_W-1:0] parValue;
  logic [CNT_W-1:0] freeCount;

  // parallel value: clip to all ones when upper bits are set
  generate
    if (DATA_W > OFS_W) begin : g_clip
      assign parValue = (|dataIn[DATA_W-1:OFS_W]) ? '1 : dataIn[OFS_W-1:0];
    end else begin : g_narrow
      assign parValue = OFS_W'(dataIn);
    end
  endgenerate

  generate
    for (genvar g = 0; g < 2; g++) begin : g_ofs
      always_ff @(posedge wrClk) begin
        if (str.defLoad) begin
          ofsReg[g] <= str.defHigh ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO);
        end else if (str.parLoad && (str.wrSel == g[0])) begin
          ofsReg[g] <= parValue;
        end else if (str.serLoad && (str.wrSel == g[0])) begin
          ofsReg[g][bitPos] <= str.serBit;
        end
      end
    end
  endgenerate

  always_ff @(posedge rdClk) begin
    if (!mrstN)          dataOut <= '0;
    else if (str.rdLoad) dataOut <= DATA_W'(ofsReg[str.rdSel]);
  end

  always_ff @(posedge rdClk) begin
    if (!mrstN) paeN <= 1'b0;
    else        paeN <= !(fillCount <= CNT_W'(ofsReg[0]));
  end

  assign freeCount = DEPTH_C - fillCount;

  always_ff @(posedge wrClk) begin
    if (!mrstN) pafN <= 1'b1;
    else        pafN <= !(freeCount <= CNT_W'(ofsReg[1]));
  end

  assert_ofs_hold_R10: assert property (@(posedge wrClk) disable iff (!mrstN)
    (!$past(str.parLoad) && !$past(str.serLoad) && !$past(str.defLoad))
      |-> ($stable(ofsReg[0]) && $stable(ofsReg[1])));

  assert_dout_hold_R6: assert property (@(posedge rdClk) disable iff (!mrstN)
    (!$past(str.rdLoad) && $past(mrstN)) |-> $stable(dataOut));

  assert_empty_flags_R8: assert property (@(posedge rdClk) disable iff (!mrstN)
    ($past(fillCount) == '0 && $past(mrstN)) |-> !paeN);

  assert_full_flags_R9: assert property (@(posedge wrClk) disable iff (!mrstN)
    ($past(fillCount) == DEPTH_C && $past(mrstN)) |-> !pafN);
endmodule

// File: rtl/almost_level_unit.sv
module almost_level_unit
  import alf_pkg::*;
#(
  parameter int DEPTH  = 8192,
  parameter int DATA_W = 18,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BIT_W = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              prstN,
  input  logic              ofsLoad,
  input  logic              wrEn,
  input  logic              serEn,
  input  logic              serIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  fillCount,
  output logic [DATA_W-1:0] dataOut,
  output logic              paeN,
  output logic              pafN
);
  alf_strobe_t      str;
  logic [BIT_W-1:0] bitPos;

  alf_ctrl #(.OFS_W(OFS_W)) i_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .ofsLoad(ofsLoad), .wrEn(wrEn), .serEn(serEn), .serIn(serIn),
    .rdEn(rdEn), .str(str), .bitPos(bitPos)
  );

  alf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) i_dp (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .str(str), .bitPos(bitPos),
    .dataIn(dataIn), .fillCount(fillCount), .dataOut(dataOut),
    .paeN(paeN), .pafN(pafN)
  );
endmodule

// File: tb/test_almost_level_unit.sv
module test_almost_level_unit;
  localparam int DEPTH  = 8192;
  localparam int DATA_W = 18;
  localparam int OFS_W  = 13;
  localparam int CNT_W  = 14;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic mrstN = 1'b0, prstN = 1'b1, ofsLoad = 1'b0;
  logic wrEn = 1'b0, serEn = 1'b0, serIn = 1'b0, rdEn = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [CNT_W-1:0]  fillCount = '0;
  logic [DATA_W-1:0] dataOut;
  logic paeN, pafN;

  int checks = 0;
  int fails  = 0;
  int expAe, expAf;
  bit finished = 1'b0;

  always #2.5 wrClk = ~wrClk;
  always #3.5 rdClk = ~rdClk;

  almost_level_unit i_almost_level_unit (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .ofsLoad(ofsLoad), .wrEn(wrEn), .serEn(serEn), .serIn(serIn),
    .dataIn(dataIn), .rdEn(rdEn), .fillCount(fillCount),
    .dataOut(dataOut), .paeN(paeN), .pafN(pafN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic masterReset(input logic sel);
    @(negedge wrClk);
    mrstN = 1'b0; ofsLoad = sel;
    repeat (3) @(negedge wrClk);
    repeat (2) @(negedge rdClk);
    @(negedge wrClk);
    mrstN = 1'b1; ofsLoad = 1'b0;
  endtask

  task automatic partialReset();
    @(negedge wrClk);
    prstN = 1'b0;
    repeat (2) @(negedge wrClk);
    repeat (2) @(negedge rdClk);
    @(negedge wrClk);
    prstN = 1'b1;
  endtask

  task automatic writePar(input int val);
    @(negedge wrClk);
    wrEn = 1'b1; ofsLoad = 1'b1; dataIn = DATA_W'(val);
    @(negedge wrClk);
    wrEn = 1'b0; ofsLoad = 1'b0;
  endtask

  task automatic shiftBit(input logic b);
    @(negedge wrClk);
    serEn = 1'b1; ofsLoad = 1'b1; serIn = b;
    @(negedge wrClk);
    serEn = 1'b0; ofsLoad = 1'b0;
  endtask

  task automatic serialPair(input int ae, input int af);
    for (int i = 0; i < OFS_W; i++) shiftBit(ae[i]);
    for (int i = 0; i < OFS_W; i++) shiftBit(af[i]);
  endtask

  task automatic readOfs(output int val);
    @(negedge rdClk);
    rdEn = 1'b1; ofsLoad = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0; ofsLoad = 1'b0;
    val = int'(dataOut);
  endtask

  task automatic readPair(input string req);
    int v;
    partialReset();
    readOfs(v); check({req, " empty-side readback"}, v, expAe);
    readOfs(v); check({req, " full-side readback"}, v, expAf);
  endtask

  task automatic checkFlags(input int cnt, input string req);
    fillCount = CNT_W'(cnt);
    repeat (2) @(negedge rdClk);
    repeat (2) @(negedge wrClk);
    check({req, " paeN"}, int'(paeN), (cnt <= expAe) ? 0 : 1);
    check({req, " pafN"}, int'(pafN), ((DEPTH - cnt) <= expAf) ? 0 : 1);
  endtask

  // R1 defaults and flags after master reset with load-select low
  task automatic testDefaultLow();
    masterReset(1'b0);
    expAe = 127; expAf = 127;
    readPair("R1");
    checkFlags(0, "R1/R8/R9 empty");
  endtask

  // R3 parallel sequence with wrap, R6 readback wrap
  task automatic testParallel();
    int v;
    writePar(100); writePar(7000); writePar(55);
    expAe = 55; expAf = 7000;
    partialReset();
    readOfs(v); check("R3 first slot after wrap", v, 55);
    readOfs(v); check("R3 second slot", v, 7000);
    readOfs(v); check("R6 readback wraps to empty side", v, 55);
  endtask

  // R5 serial strobes ignored while parallel method active
  task automatic testSerialIgnored();
    partialReset();
    for (int i = 0; i < 2 * OFS_W; i++) shiftBit(1'b1);
    readPair("R5 serial ignored");
  endtask

  // R10 enables without load-select; R6 hold
  task automatic testNoSelect();
    int held;
    @(negedge wrClk);
    wrEn = 1'b1; serEn = 1'b1; dataIn = 3;
    repeat (4) @(negedge wrClk);
    wrEn = 1'b0; serEn = 1'b0;
    readPair("R10 write without select");
    held = int'(dataOut);
    @(negedge rdClk); rdEn = 1'b1;
    repeat (3) @(negedge rdClk); rdEn = 1'b0;
    check("R10 read without select holds dataOut", int'(dataOut), held);
    repeat (3) @(negedge rdClk);
    check("R6 dataOut holds when idle", int'(dataOut), held);
  endtask

  // R11 clipping of oversized parallel value
  task automatic testClip();
    partialReset();
    writePar(20000); writePar(200);
    expAe = DEPTH - 1; expAf = 200;
    readPair("R11 clip");
  endtask

  // R8 / R9 thresholds at their boundaries
  task automatic testFlags();
    partialReset();
    writePar(55); writePar(7000);
    expAe = 55; expAf = 7000;
    checkFlags(55, "R8 at threshold");
    checkFlags(56, "R8 above threshold");
    checkFlags(1192, "R9 at threshold");
    checkFlags(1191, "R9 below threshold");
    checkFlags(DEPTH, "R9 full");
  endtask

  // R2 defaults with load-select high; R5 parallel ignored
  task automatic testDefaultHigh();
    fillCount = '0;
    masterReset(1'b1);
    expAe = 1023; expAf = 1023;
    readPair("R2");
    writePar(5); writePar(6);
    readPair("R5 parallel ignored");
  endtask

  // R4 serial load, LSB first
  task automatic testSerial();
    partialReset();
    serialPair(32'h0A5, 32'h1234);
    expAe = 'h0A5; expAf = 'h1234;
    readPair("R4");
  endtask

  // R7 partial reset mid serial stream keeps offsets and method
  task automatic testPartialMid();
    partialReset();
    for (int i = 0; i < 5; i++) shiftBit(1'b0);
    partialReset();
    for (int i = 0; i < OFS_W; i++) shiftBit(logic'((32'h0F0 >> i) & 1));
    expAe = 'h0F0;
    readPair("R7 rewind");
    writePar(9);
    readPair("R7 method kept");
  endtask

  initial begin
    testDefaultLow();
    testParallel();
    testSerialIgnored();
    testNoSelect();
    testClip();
    testFlags();
    testDefaultHigh();
    testSerial();
    testPartialMid();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule